// File: doc/BRIEF.md
# Dual-Section Decade Ripple Counter

The block holds two counting sections that share nothing but the forcing controls. The low section is a single toggle stage. It advances on each falling edge of its count clock `cnt_clk_a` and drives `cnt_q0`. The high section counts modulo five on falling edges of its own count clock `cnt_clk_b` and drives `cnt_q3..cnt_q1`. No internal path joins `cnt_q0` to the high section. When a board ties `cnt_q0` to `cnt_clk_b`, the pair forms a 2 x 5 chain, and `{cnt_q3,cnt_q2,cnt_q1,cnt_q0}` then counts in BCD from 0 to 9.

Both count clocks are ordinary data inputs. They are sampled on the system clock `clk`, and a falling edge is a sample of 1 followed by a sample of 0. Each level must therefore last at least one `clk` period. Two qualifier pairs force the count:
- When both zero lines are high, the outputs are forced to 0.
- When both nine lines are high, the outputs are forced to 1001, and this overrides the zero pair.

A forced value reaches the outputs through combinational logic in the same cycle, without waiting for a count edge. It is also loaded into the state at the next `clk` edge. In the chained hookup the high section advances one `clk` cycle after `cnt_q0` falls, which gives a one-cycle ripple.

Top module: `decade_ripple_counter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, all state and edge history clear. After that edge the outputs read 0000 unless a forcing pair is active.
- R2: When `cnt_clk_a` is sampled 1 and then 0 on consecutive `clk` edges, `cnt_q0` toggles at the second edge. A rise of `cnt_clk_a` leaves it unchanged.
- R3: The high section steps through `{cnt_q3,cnt_q2,cnt_q1}` = 000, 001, 010, 011, 100, 000 on successive falling edges of `cnt_clk_b` (modulus 5). Each step appears after the detecting `clk` edge.
- R4: Used alone, the high section holds `cnt_q3` high for exactly one of every five count states, giving a 4:1 low-to-high ratio.
- R5: Edges of `cnt_clk_a` never change `cnt_q3..cnt_q1`, and edges of `cnt_clk_b` never change `cnt_q0`.
- R6: With `cnt_q0` wired to `cnt_clk_b`, successive falling edges of `cnt_clk_a` give the BCD values 1, 2, ..., 9, 0 on `{cnt_q3..cnt_q0}`.
- R7: When `zero_req1` and `zero_req2` are both high and the nine pair is not both high, the outputs read 0000 in that same cycle, and count edges are ignored.
- R8: With only one zero line high, counting is unaffected.
- R9: When `nine_req1` and `nine_req2` are both high, the outputs read 1001 (`cnt_q3`=1, `cnt_q0`=1) in that same cycle, whatever the zero lines are.
- R10: With only one nine line high, counting is unaffected.
- R11: After a forcing pair is released, counting resumes from the forced value. In the chained hookup, one falling edge of `cnt_clk_a` after a nine force gives 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk_a | input | 1 | Count clock of the toggle section, falling edge active |
| cnt_clk_b | input | 1 | Count clock of the modulo-5 section, falling edge active |
| zero_req1 | input | 1 | Zero-force qualifier, first line |
| zero_req2 | input | 1 | Zero-force qualifier, second line |
| nine_req1 | input | 1 | Nine-force qualifier, first line |
| nine_req2 | input | 1 | Nine-force qualifier, second line |
| cnt_q0 | output | 1 | Toggle section output, BCD weight 1 |
| cnt_q1 | output | 1 | Modulo-5 bit 0, BCD weight 2 |
| cnt_q2 | output | 1 | Modulo-5 bit 1, BCD weight 4 |
| cnt_q3 | output | 1 | Modulo-5 bit 2, BCD weight 8 |

## Verification
Each section is first driven on its own clock while the other clock is idle. This separates a design that leaks edges between the sections from one that keeps them apart. The high section is then run alone for two full cycles to confirm the modulus and the single high state in five. The chained hookup is run through twenty pulses, which exposes wrong wrap points and missing ripple timing. Single-line and dual-line forcing patterns are applied in the middle of a count. These separate correct qualifier decoding and nine-over-zero priority from designs that react to one line or pick the wrong winner.

// File: rtl/decade_pkg.sv
// Package: shared constants and force type for the decade ripple counter.
// Assumes the high section stores its count in plain binary.
package decade_pkg;
    localparam int HI_MOD = 5;
    localparam int HI_W = $clog2(HI_MOD);
    localparam logic [HI_W-1:0] HI_NINE = HI_W'(HI_MOD - 1);

    typedef struct packed {
        logic nine;
        logic zero;
    } force_t;
endpackage

// File: rtl/fall_detect.sv
// Module: fall_detect
// Flags a falling edge of a slow level input sampled on clk.
// Assumes each level of lvl lasts at least one clk period.
module fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev;

    // Keep the previous sample of the level input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/lo_stage.sv
// Module: lo_stage
// Toggle section: divides its count clock by two.
// Assumes the nine force has priority over the zero force, decoded upstream.
module lo_stage
    import decade_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fall,
    input  force_t frc,
    output logic   q
);
    // Load a forced value, or toggle on a detected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (frc.nine) q <= 1'b1;
        else if (frc.zero) q <= 1'b0;
        else if (fall)     q <= ~q;
    end

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !frc.nine && !frc.zero) |=> (q != $past(q)));
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !frc.nine && !frc.zero) |=> $stable(q));
endmodule

// File: rtl/hi_stage.sv
// Module: hi_stage
// Modulo-MOD section counting in binary on falling edges of its own clock.
// Assumes the nine force loads MOD-1 and has priority over the zero force.
module hi_stage
    import decade_pkg::*;
#(
    parameter int MOD = HI_MOD,
    localparam int W = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  force_t       frc,
    output logic [W-1:0] st
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    // Load a forced value, or advance and wrap on a detected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        st <= '0;
        else if (frc.nine) st <= TOP;
        else if (frc.zero) st <= '0;
        else if (fall)     st <= (st == TOP) ? '0 : st + W'(1);
    end

    assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st <= TOP);
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !frc.nine && !frc.zero && st == TOP) |=> (st == '0));
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !frc.nine && !frc.zero) |=> $stable(st));
endmodule

// File: rtl/decade_ripple_counter.sv
// Module: decade_ripple_counter
// Two independent falling-edge count sections (divide-by-2 and divide-by-5)
// with qualified zero and nine forcing. Forces reach the outputs in the same
// cycle and load the state on the next clk edge. Assumes the count clocks are
// slow level inputs sampled on clk.
module decade_ripple_counter
    import decade_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_clk_a,
    input  logic cnt_clk_b,
    input  logic zero_req1,
    input  logic zero_req2,
    input  logic nine_req1,
    input  logic nine_req2,
    output logic cnt_q0,
    output logic cnt_q1,
    output logic cnt_q2,
    output logic cnt_q3
);
    localparam int NCLK = 2;

    logic [NCLK-1:0] clk_vec;
    logic [NCLK-1:0] fall_vec;
    force_t          frc;
    logic            lo_q;
    logic [HI_W-1:0] hi_st;
    logic [HI_W-1:0] hi_out;

    assign clk_vec = {cnt_clk_b, cnt_clk_a};

    // Decode the qualifier pairs; nine wins over zero.
    always_comb begin
        frc.nine = nine_req1 & nine_req2;
        frc.zero = zero_req1 & zero_req2 & ~frc.nine;
    end

    for (genvar g = 0; g < NCLK; g++) begin : g_edge
        fall_detect u_fall (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (clk_vec[g]),
            .fall (fall_vec[g])
        );
    end

    lo_stage u_lo (
        .clk  (clk),
        .rst_n(rst_n),
        .fall (fall_vec[0]),
        .frc  (frc),
        .q    (lo_q)
    );

    hi_stage #(.MOD(HI_MOD)) u_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .fall (fall_vec[1]),
        .frc  (frc),
        .st   (hi_st)
    );

    // Drive the outputs, letting an active force bypass the stored count.
    always_comb begin
        if (frc.nine) begin
            cnt_q0 = 1'b1;
            hi_out = HI_NINE;
        end else if (frc.zero) begin
            cnt_q0 = 1'b0;
            hi_out = '0;
        end else begin
            cnt_q0 = lo_q;
            hi_out = hi_st;
        end
    end

    assign {cnt_q3, cnt_q2, cnt_q1} = hi_out;

    assert_nine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_req1 && nine_req2) |-> ({cnt_q3, cnt_q2, cnt_q1, cnt_q0} == 4'b1001));
    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req1 && zero_req2 && !(nine_req1 && nine_req2))
            |-> ({cnt_q3, cnt_q2, cnt_q1, cnt_q0} == 4'b0000));
endmodule

// File: tb/sim_decade_ripple_counter.sv
// Bench: behavioural reference model compared on every clock, plus named checks.
module sim_decade_ripple_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cka = 1'b0, ckb_drv = 1'b0, cascade = 1'b0;
    logic z1 = 1'b0, z2 = 1'b0, n1 = 1'b0, n2 = 1'b0;
    logic q0, q1, q2, q3;
    logic ckb_wire;
    int total = 0, bad = 0;
    bit armed = 1'b0;
    string cur_req = "R1";

    int m2 = 0, m5 = 0;
    bit pa = 0, pb = 0;

    always #4 clk = ~clk;

    assign ckb_wire = cascade ? q0 : ckb_drv;

    decade_ripple_counter u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clk_a(cka), .cnt_clk_b(ckb_wire),
        .zero_req1(z1), .zero_req2(z2), .nine_req1(n1), .nine_req2(n2),
        .cnt_q0(q0), .cnt_q1(q1), .cnt_q2(q2), .cnt_q3(q3)
    );

    function automatic logic [3:0] expect_now();
        bit nine = n1 && n2;
        bit zero = z1 && z2 && !nine;
        int hi = nine ? 4 : (zero ? 0 : m5);
        int lo = nine ? 1 : (zero ? 0 : m2);
        return {hi[2:0], lo[0]};
    endfunction

    // Reference model: updates on each rising clk from the inputs seen there.
    always @(posedge clk) begin
        logic [3:0] e;
        bit cur_b, fa, fb;
        e = expect_now();
        cur_b = cascade ? e[0] : ckb_drv;
        if (!rst_n) begin
            m2 = 0; m5 = 0; pa = 0; pb = 0;
        end else begin
            fa = pa && !cka;
            fb = pb && !cur_b;
            pa = cka;
            pb = cur_b;
            if (n1 && n2) begin
                m2 = 1; m5 = 4;
            end else if (z1 && z2) begin
                m2 = 0; m5 = 0;
            end else begin
                if (fa) m2 = m2 ^ 1;
                if (fb) m5 = (m5 + 1) % 5;
            end
        end
    end

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare with the model on every falling clk, before new stimulus lands.
    always @(negedge clk) begin
        if (armed) chk(cur_req, {q3, q2, q1, q0}, expect_now());
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(output logic sig, input logic v);
        @(negedge clk);
        #1 sig = v;
    endtask

    task automatic pulse_a();
        drive(cka, 1'b1);
        drive(cka, 1'b0);
        idle(3);
    endtask

    task automatic pulse_b();
        drive(ckb_drv, 1'b1);
        drive(ckb_drv, 1'b0);
        idle(3);
    endtask

    initial begin
        int highs;
        idle(3);
        armed = 1'b1;
        cur_req = "R1";
        chk("R1", {q3, q2, q1, q0}, 4'b0000);
        drive(rst_n, 1'b1);
        idle(2);

        cur_req = "R2";
        drive(cka, 1'b1);
        idle(2);
        chk("R2", {q3, q2, q1, q0}, 4'b0000);   // rising edge alone: no change
        drive(cka, 1'b0);
        idle(2);
        chk("R2", {q3, q2, q1, q0}, 4'b0001);
        pulse_a();
        chk("R2", {q3, q2, q1, q0}, 4'b0000);
        pulse_a();

        cur_req = "R5";
        pulse_b();
        pulse_b();
        chk("R5", {q3, q2, q1, q0}, 4'b0101);   // q0 untouched by b edges

        cur_req = "R7";
        drive(z1, 1'b1);
        #1 z2 = 1'b1;
        idle(1);
        chk("R7", {q3, q2, q1, q0}, 4'b0000);
        pulse_a();
        pulse_b();
        chk("R7", {q3, q2, q1, q0}, 4'b0000);
        drive(z1, 1'b0);
        #1 z2 = 1'b0;
        idle(2);

        cur_req = "R3";
        highs = 0;
        for (int k = 1; k <= 10; k++) begin
            pulse_b();
            chk("R3", {q3, q2, q1, 1'b0}, 4'((k % 5) << 1));
            if (q3) highs++;
        end
        chk("R4", 4'(highs), 4'd2);

        cur_req = "R8";
        drive(z1, 1'b1);
        pulse_a();
        pulse_b();
        chk("R8", {q3, q2, q1, q0}, 4'b0011);
        drive(z1, 1'b0);

        cur_req = "R10";
        drive(n2, 1'b1);
        pulse_a();
        pulse_b();
        chk("R10", {q3, q2, q1, q0}, 4'b0100);
        drive(n2, 1'b0);

        cur_req = "R9";
        drive(z1, 1'b1);
        #1 z2 = 1'b1; n1 = 1'b1; n2 = 1'b1;
        idle(1);
        chk("R9", {q3, q2, q1, q0}, 4'b1001);
        drive(n1, 1'b0);
        #1 n2 = 1'b0;
        idle(1);
        chk("R7", {q3, q2, q1, q0}, 4'b0000);

        cur_req = "R6";
        #1 cascade = 1'b1;
        drive(z1, 1'b0);
        #1 z2 = 1'b0;
        idle(2);
        for (int k = 1; k <= 20; k++) begin
            pulse_a();
            chk("R6", {q3, q2, q1, q0}, 4'(k % 10));
        end

        cur_req = "R9";
        for (int k = 0; k < 4; k++) pulse_a();
        drive(n1, 1'b1);
        #1 n2 = 1'b1;
        idle(1);
        chk("R9", {q3, q2, q1, q0}, 4'b1001);
        drive(n1, 1'b0);
        #1 n2 = 1'b0;
        idle(2);
        cur_req = "R11";
        pulse_a();
        chk("R11", {q3, q2, q1, q0}, 4'b0000);
        for (int k = 0; k < 3; k++) pulse_a();
        cur_req = "R7";
        drive(z1, 1'b1);
        #1 z2 = 1'b1;
        idle(2);
        chk("R7", {q3, q2, q1, q0}, 4'b0000);
        drive(z1, 1'b0);
        #1 z2 = 1'b0;
        idle(2);
        cur_req = "R11";
        pulse_a();
        chk("R11", {q3, q2, q1, q0}, 4'b0001);

        cur_req = "R1";
        pulse_a();
        pulse_a();
        drive(rst_n, 1'b0);
        idle(2);
        chk("R1", {q3, q2, q1, q0}, 4'b0000);
        drive(rst_n, 1'b1);
        idle(2);
        chk("R1", {q3, q2, q1, q0}, 4'b0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule